// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a register-programmed timer with five down-counting channels. A shared 8-bit prescaler divides the input clock for each of two channel groups. Channels 0 and 1 form the first group, and channels 2 to 4 form the second. Each channel then applies its own power-of-two divider to the group tick. This gives a channel tick rate of clk / ((prescale + 1) * 2^k).

Software writes count and compare values into buffer registers. These values move into the active counter only on a manual update or an automatic reload at zero. Channels 0 to 3 drive PWM pins, and each pin has optional inversion. Channel 4 has no pin. Loaded with its all-ones maximum, it runs as a free-running countdown timebase.

Access uses a single-cycle synchronous port. A write takes effect at the clock edge where we_i is high. Reads are combinational from addr_i. Address bits [4:3] select a page, and bits [2:0] select an index within that page.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register and every counter reads 0, and all four PWM outputs are low.
- R2: Register reads return what was written, at these addresses:
  - Address 0 holds the group prescalers: bits [7:0] for channels 0 and 1, bits [15:8] for channels 2 to 4.
  - Address 1 holds a 4-bit divider code per channel, at bits [4n+3:4n].
  - Address 2 holds the control register.
  - Addresses 8+n hold the count buffers, and addresses 16+n hold the compare buffers.
  - Addresses 24+n are read-only counter values.
  - Channel 4's compare buffer and control bit 19 always read 0. Unused addresses read 0.
- R3: While started, a channel decrements once per tick of its group prescaler and divider. Channels 0 and 1 use bits [7:0] of address 0, and channels 2 to 4 use bits [15:8].
- R4: Divider codes 0 to 4 divide the group tick by 1, 2, 4, 8 or 16. Any code above 4 divides by 16.
- R5: Writing a count or compare buffer does not change the running counter, or the compare value in use, until the next update or reload.
- R6: While a channel's manual-update bit is set, the counter and active compare load from the buffers on every clock. The update bit is control bit 4n+1 for channels 0 to 3 and bit 17 for channel 4.
- R7: When a started channel reaches 0 on a tick, it reloads count and compare from the buffers if its auto-reload bit is set. Otherwise it stays at 0. The auto-reload bit is control bit 4n+3 for channels 0 to 3 and bit 18 for channel 4.
- R8: The start bit is control bit 4n, or bit 16 for channel 4. When it is clear, the counter holds its value and the PWM output sits at its inactive level.
- R9: A started output is high while the counter is above the active compare value, and low otherwise. A compare value of count − D therefore gives D high ticks per period.
- R10: A compare value larger than the loaded count keeps the output active for the whole period.
- R11: The inverter bit, control bit 4n+2 for channels 0 to 3, flips the output polarity. This includes the inactive level.
- R12: Channel 4, loaded with all ones and auto-reload set, counts down to 0 and wraps back to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address (page in [4:3], index in [2:0]) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| pwm_o | output | 4 | PWM outputs of channels 0 to 3 |

## Verification
A wrong prescaler or divider phase shows up on the pins within one tick period as an edge in the wrong cycle. The bench sees it because it compares the pins against a behavioural model on every clock. A corrupted active compare or reload value first appears at the next reload or compare crossing, up to one full period later. Reading the counter page exposes a wrong counter state as soon as it is read, without waiting for an edge. Channel 4 has no pin, so its wrap is checked through its counter readback after a full 65536-tick period.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  localparam int NCH      = 5;
  localparam int NOUT     = 4;
  localparam int NGRP     = 2;
  localparam int GRP0_CH  = 2;   // channels below this use group 0
  localparam int PSC_W    = 8;
  localparam int DSEL_W   = 4;
  localparam int MAX_LOG  = 4;   // largest divide is 2**MAX_LOG
  localparam int NIB      = 4;
  localparam int CTRL_W   = NIB * NCH;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam logic [CTRL_W-1:0] CTRL_MASK = {1'b0, {(CTRL_W-1){1'b1}}};

  typedef enum logic [1:0] {
    PG_CFG  = 2'd0,
    PG_CNTB = 2'd1,
    PG_CMPB = 2'd2,
    PG_OBS  = 2'd3
  } page_e;

  function automatic int ar_pos(int ch);
    return (ch < NOUT) ? NIB*ch + 3 : NIB*ch + 2;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int PSC_W  = 8,
  parameter int DCNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PSC_W-1:0]  psc_i,
  output logic              tick_o,
  output logic [DCNT_W-1:0] dcnt_o
);
  logic [PSC_W-1:0]  pcnt_q;
  logic [DCNT_W-1:0] dcnt_q;

  assign tick_o = (pcnt_q >= psc_i);
  assign dcnt_o = dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (tick_o) begin
      pcnt_q <= '0;
      dcnt_q <= dcnt_q + 1'b1;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R3
  tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pcnt_q == '0));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
  parameter int CNT_W   = 16,
  parameter int DSEL_W  = 4,
  parameter int MAX_LOG = 4,
  parameter bit HAS_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_tick_i,
  input  logic [DSEL_W-1:0] grp_dcnt_i,
  input  logic [DSEL_W-1:0] dsel_i,
  input  logic              start_i,
  input  logic              upd_i,
  input  logic              inv_i,
  input  logic              ar_i,
  input  logic [CNT_W-1:0]  cntb_i,
  input  logic [CNT_W-1:0]  cmpb_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pwm_o
);
  localparam int LOG_W = $clog2(MAX_LOG + 1);

  logic [LOG_W-1:0]  dlog;
  logic [DSEL_W:0]   mask_w;
  logic [DSEL_W-1:0] mask;
  logic              tick;
  logic [CNT_W-1:0]  cnt_q, per_q, cmp_q;

  // codes above MAX_LOG clamp to the largest divide
  assign dlog   = (dsel_i > DSEL_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : LOG_W'(dsel_i);
  assign mask_w = ((DSEL_W+1)'(1) << dlog) - (DSEL_W+1)'(1);
  assign mask   = mask_w[DSEL_W-1:0];
  assign tick   = grp_tick_i && ((grp_dcnt_i & mask) == mask);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
    end else if (upd_i) begin
      cnt_q <= cntb_i;
      per_q <= cntb_i;
      cmp_q <= cmpb_i;
    end else if (start_i && tick) begin
      if (cnt_q == '0) begin
        if (ar_i) begin
          cnt_q <= cntb_i;
          per_q <= cntb_i;
          cmp_q <= cmpb_i;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  generate
    if (HAS_OUT) begin : g_out
      logic raw;
      assign raw   = (cmp_q > per_q) || (cnt_q > cmp_q);
      assign pwm_o = start_i ? (raw ^ inv_i) : inv_i;
    end else begin : g_no_out
      logic unused_sig;
      assign unused_sig = ^{inv_i, cmp_q, per_q};
      assign pwm_o = 1'b0;
    end
  endgenerate

  // R6
  upd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (cnt_q == $past(cntb_i)));
  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !upd_i) |=> $stable(cnt_q));
  // R7
  oneshot_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && tick && cnt_q == '0 && !ar_i && !upd_i) |=> (cnt_q == '0));
  // R5
  no_climb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && cnt_q != '0) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NCH-1:0][CNT_W-1:0]   obs_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NGRP-1:0][PSC_W-1:0]  psc_o,
  output logic [NCH-1:0][DSEL_W-1:0]  dsel_o,
  output logic [CTRL_W-1:0]           ctrl_o,
  output logic [NCH-1:0][CNT_W-1:0]   cntb_o,
  output logic [NCH-1:0][CNT_W-1:0]   cmpb_o
);
  page_e                       page;
  logic [2:0]                  idx;
  logic [NGRP-1:0][PSC_W-1:0]  psc_q;
  logic [NCH-1:0][DSEL_W-1:0]  dsel_q;
  logic [CTRL_W-1:0]           ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]   cntb_q, cmpb_q;

  assign page   = page_e'(addr_i[4:3]);
  assign idx    = addr_i[2:0];
  assign psc_o  = psc_q;
  assign dsel_o = dsel_q;
  assign ctrl_o = ctrl_q;
  assign cntb_o = cntb_q;
  assign cmpb_o = cmpb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      dsel_q <= '0;
      ctrl_q <= '0;
      cntb_q <= '0;
      cmpb_q <= '0;
    end else if (we_i) begin
      case (page)
        PG_CFG: begin
          case (idx)
            3'd0:    psc_q  <= wdata_i[NGRP*PSC_W-1:0];
            3'd1:    dsel_q <= wdata_i[NCH*DSEL_W-1:0];
            3'd2:    ctrl_q <= wdata_i[CTRL_W-1:0] & CTRL_MASK;
            default: ;
          endcase
        end
        PG_CNTB: begin
          for (int n = 0; n < NCH; n++)
            if (idx == 3'(n)) cntb_q[n] <= wdata_i[CNT_W-1:0];
        end
        PG_CMPB: begin
          for (int n = 0; n < NOUT; n++)
            if (idx == 3'(n)) cmpb_q[n] <= wdata_i[CNT_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (page)
      PG_CFG: begin
        case (idx)
          3'd0:    rdata_o[NGRP*PSC_W-1:0] = psc_q;
          3'd1:    rdata_o[NCH*DSEL_W-1:0] = dsel_q;
          3'd2:    rdata_o[CTRL_W-1:0]     = ctrl_q;
          default: ;
        endcase
      end
      PG_CNTB: for (int n = 0; n < NCH; n++)
                 if (idx == 3'(n)) rdata_o[CNT_W-1:0] = cntb_q[n];
      PG_CMPB: for (int n = 0; n < NCH; n++)
                 if (idx == 3'(n)) rdata_o[CNT_W-1:0] = cmpb_q[n];
      PG_OBS:  for (int n = 0; n < NCH; n++)
                 if (idx == 3'(n)) rdata_o[CNT_W-1:0] = obs_i[n];
      default: ;
    endcase
  end

  // R2
  reserved_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_q[CTRL_W-1] == 1'b0 && cmpb_q[NCH-1] == '0));
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NOUT-1:0]   pwm_o
);
  logic [NGRP-1:0][PSC_W-1:0]  psc;
  logic [NGRP-1:0]             grp_tick;
  logic [NGRP-1:0][DSEL_W-1:0] grp_dcnt;
  logic [NCH-1:0][DSEL_W-1:0]  dsel;
  logic [CTRL_W-1:0]           ctrl;
  logic [NCH-1:0][CNT_W-1:0]   cntb, cmpb, obs;
  logic [NCH-1:0]              ch_pwm;

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .obs_i   (obs),
    .rdata_o (rdata_o),
    .psc_o   (psc),
    .dsel_o  (dsel),
    .ctrl_o  (ctrl),
    .cntb_o  (cntb),
    .cmpb_o  (cmpb)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pwm_prescaler #(.PSC_W(PSC_W), .DCNT_W(DSEL_W)) u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .psc_i  (psc[g]),
      .tick_o (grp_tick[g]),
      .dcnt_o (grp_dcnt[g])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int  G       = (n < GRP0_CH) ? 0 : 1;
    localparam bit  HAS_OUT = (n < NOUT);
    localparam int  AR      = ar_pos(n);
    logic inv;
    if (HAS_OUT) begin : g_inv
      assign inv = ctrl[NIB*n+2];
    end else begin : g_noinv
      assign inv = 1'b0;
    end

    pwm_channel #(
      .CNT_W   (CNT_W),
      .DSEL_W  (DSEL_W),
      .MAX_LOG (MAX_LOG),
      .HAS_OUT (HAS_OUT)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .grp_tick_i (grp_tick[G]),
      .grp_dcnt_i (grp_dcnt[G]),
      .dsel_i     (dsel[n]),
      .start_i    (ctrl[NIB*n]),
      .upd_i      (ctrl[NIB*n+1]),
      .inv_i      (inv),
      .ar_i       (ctrl[AR]),
      .cntb_i     (cntb[n]),
      .cmpb_i     (cmpb[n]),
      .cnt_o      (obs[n]),
      .pwm_o      (ch_pwm[n])
    );
  end

  assign pwm_o = ch_pwm[NOUT-1:0];
  logic unused_pwm;
  assign unused_pwm = ^ch_pwm[NCH-1:NOUT];

  // R11
  stopped_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[0] && !$past(ctrl[0])) |-> (pwm_o[0] == ctrl[2]));
endmodule

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural reference model
  logic [15:0] m_cfg0;
  logic [19:0] m_cfg1, m_ctrl;
  int m_cntb[5], m_cmpb[5], m_cnt[5], m_per[5], m_cmpa[5];
  int m_pc[2], m_gd[2];

  function automatic int psc_of(int g);
    return (g == 0) ? int'(m_cfg0[7:0]) : int'(m_cfg0[15:8]);
  endfunction

  task automatic model_step();
    bit gt[2];
    for (int g = 0; g < 2; g++) gt[g] = (m_pc[g] >= psc_of(g));
    for (int n = 0; n < 5; n++) begin
      int g = (n < 2) ? 0 : 1;
      int k = int'(m_cfg1[4*n +: 4]);
      bit up, st, ar, tk;
      if (k > 4) k = 4;
      tk = gt[g] && ((m_gd[g] % (1 << k)) == (1 << k) - 1);
      st = m_ctrl[4*n];
      up = m_ctrl[4*n+1];
      ar = (n < 4) ? m_ctrl[4*n+3] : m_ctrl[4*n+2];
      if (up) begin
        m_cnt[n] = m_cntb[n]; m_per[n] = m_cntb[n]; m_cmpa[n] = m_cmpb[n];
      end else if (st && tk) begin
        if (m_cnt[n] == 0) begin
          if (ar) begin
            m_cnt[n] = m_cntb[n]; m_per[n] = m_cntb[n]; m_cmpa[n] = m_cmpb[n];
          end
        end else m_cnt[n] = m_cnt[n] - 1;
      end
    end
    for (int g = 0; g < 2; g++)
      if (gt[g]) begin m_pc[g] = 0; m_gd[g] = (m_gd[g] + 1) % 16; end
      else m_pc[g] = m_pc[g] + 1;
    if (we) begin
      int i = int'(addr[2:0]);
      case (addr[4:3])
        2'd0: if (i == 0) m_cfg0 = wdata[15:0];
              else if (i == 1) m_cfg1 = wdata[19:0];
              else if (i == 2) m_ctrl = wdata[19:0] & 20'h7FFFF;
        2'd1: if (i < 5) m_cntb[i] = int'(wdata[15:0]);
        2'd2: if (i < 4) m_cmpb[i] = int'(wdata[15:0]);
        default: ;
      endcase
    end
  endtask

  task automatic model_reset();
    m_cfg0 = '0; m_cfg1 = '0; m_ctrl = '0;
    for (int n = 0; n < 5; n++) begin
      m_cntb[n] = 0; m_cmpb[n] = 0; m_cnt[n] = 0; m_per[n] = 0; m_cmpa[n] = 0;
    end
    m_pc[0] = 0; m_pc[1] = 0; m_gd[0] = 0; m_gd[1] = 0;
  endtask

  function automatic logic [31:0] mread(logic [4:0] a);
    int i = int'(a[2:0]);
    case (a[4:3])
      2'd0: return (i == 0) ? {16'h0, m_cfg0} : (i == 1) ? {12'h0, m_cfg1} :
                   (i == 2) ? {12'h0, m_ctrl} : 32'h0;
      2'd1: return (i < 5) ? 32'(m_cntb[i]) : 32'h0;
      2'd2: return (i < 4) ? 32'(m_cmpb[i]) : 32'h0;
      default: return (i < 5) ? 32'(m_cnt[i]) : 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] mpwm();
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      bit raw = (m_cmpa[n] > m_per[n]) || (m_cnt[n] > m_cmpa[n]);
      bit inv = m_ctrl[4*n+2];
      r[n] = m_ctrl[4*n] ? (raw ^ inv) : inv;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // per-cycle pin comparison (R9, R10, R11 and tick timing R3/R4)
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      n_chk++;
      if (pwm !== mpwm()) begin
        n_fail++;
        $display("FAIL R9 pwm_o act %b exp %b at %0t", pwm, mpwm(), $time);
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act 0x%0h exp 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    @(negedge clk);
    addr = a;
    #2;
    chk(rdata === mread(a), tag, rdata, mread(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(pwm === 4'h0, "R1 pwm", 32'(pwm), 32'h0);
    foreach (addr_list_r1[i]) rd(addr_list_r1[i], "R1");

    // R2 readback and reserved fields
    wr(5'd0, 32'h0000_0302); rd(5'd0, "R2 cfg0");
    wr(5'd1, 32'h0004_3210); rd(5'd1, "R2 cfg1");
    wr(5'd2, 32'hFFFF_FFFF); rd(5'd2, "R2 ctrl bit19");
    chk(rdata === 32'h0007_FFFF, "R2 ctrl mask", rdata, 32'h0007_FFFF);
    wr(5'd2, 32'h0);
    wr(5'd20, 32'h55); rd(5'd20, "R2 ch4 cmp");
    chk(rdata === 32'h0, "R2 ch4 cmp zero", rdata, 32'h0);
    rd(5'd3, "R2 unused");

    // main setup: psc A=0, psc B=1; dividers 1,2,4,code7(16),1
    wr(5'd0, 32'h0000_0100);
    wr(5'd1, 32'h0000_7210);
    wr(5'd8, 32'd9);  wr(5'd16, 32'd6);   // duty 3 of 10
    wr(5'd9, 32'd5);  wr(5'd17, 32'd9);   // compare above count (R10)
    wr(5'd10, 32'd7); wr(5'd18, 32'd3);
    wr(5'd11, 32'd4); wr(5'd19, 32'd2);
    wr(5'd12, 32'd20);
    wr(5'd2, 32'h0002_2222);               // manual update all
    wr(5'd2, 32'h0005_D999);               // start + auto-reload, ch3 inverted
    for (int i = 0; i < 12; i++) begin
      idle(7);
      rd(5'd24, "R3 ch0 counter");
      rd(5'd26, "R4 ch2 counter");
      rd(5'd27, "R4 ch3 clamp counter");
      chk(pwm[1] === 1'b1, "R10 ch1 always active", 32'(pwm[1]), 32'h1);
    end
    idle(100);

    // R5 buffer write does not disturb running counter
    wr(5'd8, 32'd12);
    for (int i = 0; i < 5; i++) rd(5'd24, "R5 ch0 counter");
    idle(40);
    rd(5'd24, "R5 ch0 after reload");

    // R8 stop holds counter, output inactive
    wr(5'd2, 32'h0005_D998);
    rd(5'd24, "R8 hold a"); idle(10); rd(5'd24, "R8 hold b");
    chk(pwm[0] === 1'b0, "R8 inactive level", 32'(pwm[0]), 32'h0);

    // R7 one-shot on ch2
    wr(5'd2, 32'h0005_D198);
    idle(200);
    rd(5'd26, "R7 ch2 rests at zero");
    chk(rdata === 32'h0, "R7 zero", rdata, 32'h0);

    // R11 inverter while stopped
    wr(5'd2, 32'h0005_D194);
    idle(2);
    chk(pwm[0] === 1'b1, "R11 inverted idle", 32'(pwm[0]), 32'h1);

    // R6 held manual update on ch1
    wr(5'd2, 32'h0005_D1B4);
    idle(10); rd(5'd25, "R6 ch1 held");
    wr(5'd9, 32'd3); idle(2); rd(5'd25, "R6 ch1 follows buffer");
    wr(5'd2, 32'h0005_D194);

    // R12 channel 4 all-ones timebase wrap
    wr(5'd0, 32'h0);
    wr(5'd12, 32'h0000_FFFF);
    wr(5'd2, 32'h0002_D194);
    rd(5'd28, "R12 loaded max");
    wr(5'd2, 32'h0005_D194);
    idle(65530); rd(5'd28, "R12 near zero");
    idle(10);    rd(5'd28, "R12 wrapped");
    idle(20);    rd(5'd28, "R12 counting after wrap");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  logic [4:0] addr_list_r1[10] = '{5'd0, 5'd1, 5'd2, 5'd8, 5'd16,
                                   5'd24, 5'd25, 5'd26, 5'd27, 5'd28};

  initial begin
    #1_900_000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule